// File: doc/BRIEF.md
# Dish Control Tone Burst Transmitter

This block sends short command messages to a satellite antenna or LNB by keying a 22 kHz tone on one output pin. A host writes between one and eight message bytes, the length, the output mode and the carrier divider into a small write-only register set, then writes the start bit. The block shifts out each byte, most significant bit first, and follows it with an odd parity bit. Each bit is a tone burst followed by silence, and the burst length carries the bit value. The `busy` and `done` outputs report progress.

The pin carries one of two forms. In the first it is the gated square wave itself. In the second it is a plain level that is high wherever the tone would sound, for use with an external modulator. When no message is being sent, a continuous-tone setting can hold the carrier on the pin without gaps. Otherwise the pin rests low.

Top module: `dish_tone_tx`

## Requirements
- R1: After reset, `tone_out`, `busy` and `done` are all low. The carrier divider holds its reset parameter value, the length field selects one byte and both mode bits are clear.
- R2: Control register address 8 holds the length minus one in bits [2:0], so a value k sends k+1 bytes. An accepted message keeps `busy` high for exactly (k+1) x 9 bit periods.
- R3: A bit period is three slots, and each slot is 22 carrier half-periods. A 0 bit sounds for two slots and is then silent for one. A 1 bit sounds for one slot and is then silent for two.
- R4: The byte at address 0 is sent first and the byte at address k last. Each byte goes out bit 7 first, followed by a parity bit that makes the count of ones in the nine bits odd.
- R5: When control bit 3 is 0, the pin carries a square wave during tone slots. The wave starts high at the beginning of each tone slot and changes level every divider-value clock cycles.
- R6: When control bit 3 is 1, the pin is held steadily high for the whole of each tone slot.
- R7: A start request (address 9, data bit 0 set) that arrives while `busy` is high has no effect. The message in progress keeps its timing and its total length.
- R8: Writes to addresses 0 to 8, 10 and 11 while `busy` is high are dropped. A later message that is started without reloading sends the earlier contents.
- R9: `busy` falls only at the end of the last bit's final silent slot, and `done` rises in that same cycle. `done` clears when the next start is accepted, and `busy` and `done` are never high together.
- R10: With control bit 4 set and no message running, the pin carries the carrier without gaps. Every level lasts exactly the divider value in clock cycles.
- R11: With control bit 4 clear and no message running, `tone_out` is low.
- R12: The divider is written at address 10 (bits 7:0) and address 11 (bits 15:8). It gives the carrier half-period in clock cycles, and a value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 4 | Register address (0-7 bytes, 8 control, 9 start, 10/11 divider) |
| wr_data | input | 8 | Register write data |
| tone_out | output | 1 | Tone or envelope output to the antenna control pin |
| busy | output | 1 | High while a message is being sent |
| done | output | 1 | High after a message completes, until the next start |

## Verification
The hardest situation to reach is a host access that lands in the middle of a message. The stimulus reaches it with a capture task that watches the pin and, at a chosen cycle inside the busy window, injects a start write, a byte write and a length change. The task then decodes the whole burst pattern from the pin. The recovered bits, the busy length and a second unreloaded message together show that none of the injected writes took hold. Parity and bit order are checked by decoding envelope-mode runs against bits that the bench derives itself.

// File: rtl/dtx_pkg.sv
package dtx_pkg;
  localparam int MAX_BYTES     = 8;
  localparam int BYTE_IDX_W    = $clog2(MAX_BYTES);
  localparam int DIV_W         = 16;
  localparam int BITS_PER_BYTE = 9;
  localparam int SLOTS_PER_BIT = 3;

  localparam logic [3:0] ADDR_CTRL   = 4'd8;
  localparam logic [3:0] ADDR_START  = 4'd9;
  localparam logic [3:0] ADDR_DIV_LO = 4'd10;
  localparam logic [3:0] ADDR_DIV_HI = 4'd11;

  typedef struct packed {
    logic                  cont;
    logic                  env_mode;
    logic [BYTE_IDX_W-1:0] last_byte;
  } ctrl_t;

  // parity bit giving an odd number of ones across byte plus parity
  function automatic logic odd_parity(input logic [7:0] b);
    return ~(^b);
  endfunction

  // bit sent at position idx of a byte frame: 0..7 data MSB first, 8 parity
  function automatic logic frame_bit(input logic [7:0] b, input logic [3:0] idx);
    logic [2:0] pos;
    if (idx >= 4'd8) return odd_parity(b);
    pos = 3'd7 - idx[2:0];
    return b[pos];
  endfunction

  // number of tone slots at the start of a bit period
  function automatic logic [1:0] tone_slots(input logic v);
    return v ? 2'd1 : 2'd2;
  endfunction

  // divider value with zero mapped to one
  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
    return (d == '0) ? DIV_W'(1) : d;
  endfunction
endpackage

// File: rtl/dtx_regs.sv
module dtx_regs
  import dtx_pkg::*;
#(
  parameter logic [DIV_W-1:0] DIV_RESET = 16'd1136
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [3:0]                wr_addr,
  input  logic [7:0]                wr_data,
  input  logic                      busy,
  output logic [MAX_BYTES-1:0][7:0] msg_bytes,
  output ctrl_t                     ctrl,
  output logic [DIV_W-1:0]          div_val,
  output logic                      start_req
);
  logic cfg_we;
  assign cfg_we    = wr_en && !busy;
  assign start_req = wr_en && (wr_addr == ADDR_START) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_bytes <= '0;
    end else if (cfg_we) begin
      for (int i = 0; i < MAX_BYTES; i++) begin
        if (wr_addr == 4'(i)) msg_bytes[i] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      div_val <= DIV_RESET;
    end else if (cfg_we) begin
      case (wr_addr)
        ADDR_CTRL:   ctrl          <= ctrl_t'(wr_data[BYTE_IDX_W+1:0]);
        ADDR_DIV_LO: div_val[7:0]  <= wr_data;
        ADDR_DIV_HI: div_val[15:8] <= wr_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dtx_carrier.sv
module dtx_carrier
  import dtx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick,
  output logic             sq
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] limit;
  logic             at_limit;

  assign limit    = eff_div(div_val) - DIV_W'(1);
  assign at_limit = (cnt >= limit);
  assign tick     = at_limit && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sq  <= 1'b0;
    end else if (restart) begin
      cnt <= '0;
      sq  <= 1'b1;
    end else if (at_limit) begin
      cnt <= '0;
      sq  <= ~sq;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/dtx_sequencer.sv
module dtx_sequencer
  import dtx_pkg::*;
#(
  parameter int SLOT_TICKS = 22,
  localparam int TCNT_W    = (SLOT_TICKS > 2) ? $clog2(SLOT_TICKS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_req,
  input  logic                      tick,
  input  logic [MAX_BYTES-1:0][7:0] msg_bytes,
  input  logic [BYTE_IDX_W-1:0]     last_byte,
  output logic                      accept,
  output logic                      busy,
  output logic                      done,
  output logic                      env,
  output logic                      msg_end,
  output logic [TCNT_W-1:0]         tcnt
);
  logic [1:0]            slot_idx;
  logic [3:0]            bit_idx;
  logic [BYTE_IDX_W-1:0] byte_idx;
  logic [7:0]            cur_byte;
  logic                  cur_bit;
  logic                  slot_end, bit_end, byte_end;

  assign accept   = start_req && !busy;
  assign cur_byte = msg_bytes[byte_idx];
  assign cur_bit  = frame_bit(cur_byte, bit_idx);
  assign env      = busy && (slot_idx < tone_slots(cur_bit));

  assign slot_end = busy && tick && (tcnt == TCNT_W'(SLOT_TICKS - 1));
  assign bit_end  = slot_end && (slot_idx == 2'(SLOTS_PER_BIT - 1));
  assign byte_end = bit_end && (bit_idx == 4'(BITS_PER_BYTE - 1));
  assign msg_end  = byte_end && (byte_idx == last_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      tcnt     <= '0;
      slot_idx <= '0;
      bit_idx  <= '0;
      byte_idx <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      done     <= 1'b0;
      tcnt     <= '0;
      slot_idx <= '0;
      bit_idx  <= '0;
      byte_idx <= '0;
    end else if (busy && tick) begin
      if (!slot_end) begin
        tcnt <= tcnt + TCNT_W'(1);
      end else begin
        tcnt <= '0;
        if (!bit_end) begin
          slot_idx <= slot_idx + 2'd1;
        end else begin
          slot_idx <= '0;
          if (!byte_end) begin
            bit_idx <= bit_idx + 4'd1;
          end else begin
            bit_idx <= '0;
            if (!msg_end) begin
              byte_idx <= byte_idx + BYTE_IDX_W'(1);
            end else begin
              byte_idx <= '0;
              busy     <= 1'b0;
              done     <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/dish_tone_tx.sv
module dish_tone_tx
  import dtx_pkg::*;
#(
  parameter int               SLOT_TICKS = 22,
  parameter logic [DIV_W-1:0] DIV_RESET  = 16'd1136
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       tone_out,
  output logic       busy,
  output logic       done
);
  localparam int TCNT_W = (SLOT_TICKS > 2) ? $clog2(SLOT_TICKS) : 1;

  logic [MAX_BYTES-1:0][7:0] msg_bytes;
  ctrl_t                     ctrl;
  logic [DIV_W-1:0]          div_val;
  logic                      start_req;
  logic                      accept;
  logic                      tick;
  logic                      sq;
  logic                      env;
  logic                      msg_end;
  logic [TCNT_W-1:0]         tcnt;
  logic                      mode_env;
  logic                      cont_on;

  assign mode_env = ctrl.env_mode;
  assign cont_on  = ctrl.cont;

  dtx_regs #(.DIV_RESET(DIV_RESET)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .busy      (busy),
    .msg_bytes (msg_bytes),
    .ctrl      (ctrl),
    .div_val   (div_val),
    .start_req (start_req)
  );

  dtx_carrier u_carrier (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept),
    .div_val (div_val),
    .tick    (tick),
    .sq      (sq)
  );

  dtx_sequencer #(.SLOT_TICKS(SLOT_TICKS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .tick      (tick),
    .msg_bytes (msg_bytes),
    .last_byte (ctrl.last_byte),
    .accept    (accept),
    .busy      (busy),
    .done      (done),
    .env       (env),
    .msg_end   (msg_end),
    .tcnt      (tcnt)
  );

  always_comb begin
    if (busy)         tone_out = env && (mode_env || sq);
    else if (cont_on) tone_out = sq;
    else              tone_out = 1'b0;
  end
endmodule

// File: rtl/dtx_checker.sv
module dtx_checker #(
  parameter int TCNT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              tone_out,
  input logic              start_req,
  input logic              tick,
  input logic              sq,
  input logic              env,
  input logic              mode_env,
  input logic              cont_on,
  input logic              msg_end,
  input logic [TCNT_W-1:0] tcnt
);
  assert_idle_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cont_on) |-> !tone_out);

  assert_cont_gapless_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cont_on) |-> (tone_out == sq));

  assert_env_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && env && mode_env) |-> tone_out);

  assert_mod_square_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && env && !mode_env) |-> (tone_out == sq));

  assert_silent_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !env) |-> !tone_out);

  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_req && !tick) |=> (busy && $stable(tcnt)));

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !msg_end) |=> busy);

  assert_finish_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && msg_end) |=> (done && !busy));

  assert_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

bind dish_tone_tx dtx_checker #(.TCNT_W(TCNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .tone_out  (tone_out),
  .start_req (start_req),
  .tick      (tick),
  .sq        (sq),
  .env       (env),
  .mode_env  (mode_env),
  .cont_on   (cont_on),
  .msg_end   (msg_end),
  .tcnt      (tcnt)
);

// File: tb/dish_tone_tx_test.sv
`timescale 1ns/1ps
module dish_tone_tx_test;
  localparam int S = 22;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tone_out, busy, done;

  int n_tests = 0;
  int n_fail  = 0;
  int cur_div = 4;
  logic [7:0] msg [8];
  logic       dec [0:127];

  always #2.5 clk = ~clk;

  dish_tone_tx uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tone_out(tone_out), .busy(busy), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic exp_bit(input int k);
    logic [7:0] b;
    int p;
    b = msg[k / 9];
    p = k % 9;
    return (p < 8) ? b[7 - p] : ~(^b);
  endfunction

  task automatic load(input int n, input bit env, input bit cont);
    for (int i = 0; i < n; i++) wr(4'(i), msg[i]);
    wr(4'd8, 8'({cont, env, 3'(n - 1)}));
  endtask

  task automatic set_div(input int d);
    wr(4'd10, 8'(d));
    wr(4'd11, 8'(d >> 8));
    cur_div = (d == 0) ? 1 : d;
  endtask

  // starts a message and samples the pin until busy falls
  task automatic capture(input int poke_at, output int busy_cyc, output int highs,
                         output int max_run, output int nbits, output int first_done);
    int run, it;
    run = 0; busy_cyc = 0; highs = 0; max_run = 0; nbits = 0; it = 0;
    wr(4'd9, 8'h01);
    first_done = done;
    while (busy && it < 40000) begin
      busy_cyc++;
      if (tone_out) begin
        highs++; run++;
        if (run > max_run) max_run = run;
      end else if (run > 0) begin
        if (nbits < 128) dec[nbits] = (run == S * cur_div);
        nbits++;
        run = 0;
      end
      if (it == poke_at)     begin wr_en = 1'b1; wr_addr = 4'd9; wr_data = 8'h01; end
      if (it == poke_at + 1) begin wr_en = 1'b1; wr_addr = 4'd0; wr_data = 8'hFF; end
      if (it == poke_at + 2) begin wr_en = 1'b1; wr_addr = 4'd8; wr_data = 8'h1F; end
      if (it == poke_at + 3) wr_en = 1'b0;
      it++;
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  function automatic int bit_errors(input int nb);
    int e = 0;
    for (int k = 0; k < nb; k++) if (dec[k] !== exp_bit(k)) e++;
    return e;
  endfunction

  task automatic t_reset();
    check("R1 tone_out after reset", tone_out, 0);
    check("R1 busy after reset", busy, 0);
    check("R1 done after reset", done, 0);
  endtask

  task automatic t_one_byte_env();
    int bc, hi, mr, nb, fd;
    msg[0] = 8'hA5;
    load(1, 1'b1, 1'b0);
    capture(-10, bc, hi, mr, nb, fd);
    check("R2 busy length one byte", bc, 9 * 3 * S * cur_div);
    check("R3 bit count one byte", nb, 9);
    check("R4 bits of A5", bit_errors(9), 0);
    check("R6 longest level run", mr, 2 * S * cur_div);
    check("R9 done after finish", done, 1);
    check("R11 pin low after finish", tone_out, 0);
  endtask

  task automatic t_eight_env();
    int bc, hi, mr, nb, fd;
    msg[0] = 8'h00; msg[1] = 8'hFF; msg[2] = 8'h01; msg[3] = 8'h80;
    msg[4] = 8'h5A; msg[5] = 8'hC3; msg[6] = 8'h7E; msg[7] = 8'h96;
    load(8, 1'b1, 1'b0);
    capture(-10, bc, hi, mr, nb, fd);
    check("R2 busy length eight bytes", bc, 72 * 3 * S * cur_div);
    check("R3 bit count eight bytes", nb, 72);
    check("R4 bits of eight bytes", bit_errors(72), 0);
  endtask

  task automatic t_modulated();
    int bc, hi, mr, nb, fd, slots;
    msg[0] = 8'h3C;
    load(1, 1'b0, 1'b0);
    slots = 0;
    for (int k = 0; k < 9; k++) slots += exp_bit(k) ? 1 : 2;
    capture(-10, bc, hi, mr, nb, fd);
    check("R5 high cycles modulated", hi, slots * (S / 2) * cur_div);
    check("R5 longest high run", mr, cur_div);
    check("R2 busy length modulated", bc, 9 * 3 * S * cur_div);
  endtask

  task automatic t_busy_writes();
    int bc, hi, mr, nb, fd;
    msg[0] = 8'h12; msg[1] = 8'h34;
    load(2, 1'b1, 1'b0);
    capture(300, bc, hi, mr, nb, fd);
    check("R7 busy length with mid start", bc, 18 * 3 * S * cur_div);
    check("R8 bits unchanged by writes", bit_errors(18), 0);
    check("R9 done set before restart", done, 1);
    capture(-10, bc, hi, mr, nb, fd);
    check("R9 done cleared by start", fd, 0);
    check("R8 second message length", bc, 18 * 3 * S * cur_div);
    check("R8 second message bits", bit_errors(18), 0);
  endtask

  task automatic run_check(input string req, input int d);
    int run, bad, runs;
    logic prev;
    repeat (20) @(negedge clk);
    prev = tone_out; run = -1; bad = 0; runs = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (tone_out !== prev) begin
        if (run > 0) begin runs++; if (run != d) bad++; end
        run = 1;
        prev = tone_out;
      end else if (run > 0) begin
        run++;
      end else if (run < 0 && i > 0) begin
        run = -1;
      end
    end
    check({req, " irregular runs"}, bad, 0);
    check({req, " enough transitions"}, int'(runs >= 400 / d - 4), 1);
  endtask

  task automatic t_continuous();
    wr(4'd8, 8'h10);
    run_check("R10 continuous div 4", 4);
    set_div(6);
    run_check("R12 divider 6", 6);
    set_div(0);
    run_check("R12 divider 0 as 1", 1);
    set_div(4);
    wr(4'd8, 8'h00);
  endtask

  task automatic t_idle();
    int hi = 0;
    repeat (20) @(negedge clk);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (tone_out) hi++;
    end
    check("R11 idle pin stays low", hi, 0);
    check("R11 idle busy low", busy, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    set_div(4);
    t_one_byte_env();
    t_eight_env();
    t_modulated();
    t_busy_writes();
    t_continuous();
    t_idle();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule